// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block sits on the host side of an 8-bit NAND flash bus. In that bus, commands, addresses and write data all share one byte-wide I/O path. A client raises a one-cycle `start` together with an operation code, a 12-bit column and a 17-bit row. The sequencer then produces the chip-enable, command-latch, address-latch and write-enable strobes, and drives each byte onto the I/O lines. Each byte is taken by the flash on the rising edge of the write-enable strobe.

Operations with an execute byte are page read, read for copy-back, page program, cache program, copy-back program and block erase. For these, the sequencer holds the chip selected after the last byte. It waits until the ready/busy line goes low and then high again, and only then reports completion. Status read, ID read and reset use a single command byte and finish right after it. Program payload moves through a byte handshake: the block acknowledges each byte as it takes it, and the host marks the final byte.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset, and whenever no operation is in progress, `ce_n` and `we_n` are high, `cle`, `ale`, `io_oe`, `done`, `err` and `data_ack` are low, and `busy` is low.
- R2: Every bus byte is sent in one slot. In a slot, `ce_n` is low, `we_n` is low for exactly `TLOW` clocks and then high for `THIGH` clocks, and `io_out`, `cle` and `ale` stay constant while `we_n` is low.
- R3: `cle` is high only in command slots and `ale` is high only in address slots. The two are never high together.
- R4: The `op` codes are 0 read (00h, 30h), 1 read for copy-back (00h, 35h), 2 page program (80h, 10h), 3 cache program (80h, 15h) and 4 copy-back program (85h, 10h). For each of these, five address bytes follow the first command byte, in this order: `col[7:0]`, `{4'b0,col[11:8]}`, `row[7:0]`, `row[15:8]`, `{7'b0,row[16]}`. The second command byte comes after the address bytes, or after the data bytes when the operation has them. Column values up to 2111 are sent unchanged.
- R5: Code 5 is block erase. It sends 60h, then only the three row bytes in the order given in R4, then D0h.
- R6: Codes 6 (70h), 7 (90h) and 8 (FFh) each send one command byte. `done` then pulses without waiting on `rb_n`.
- R7: Codes 2 and 3 send payload bytes between the address phase and the second command, with `cle` and `ale` low. `data_ack` is high in the first cycle of each payload slot. The byte on `wdata` at that time is the byte being sent. The slot whose byte had `wlast` high is the final payload slot.
- R8: After the second command byte of codes 0 to 5, `done` stays low until `rb_n` has been seen low and then high. `done` rises in the cycle after `rb_n` is sampled high.
- R9: A `start` while `busy` is high is ignored and does not disturb the bus sequence in progress. `err` is high in the next cycle.
- R10: A `start` with a code above 8 starts no bus activity (`ce_n` stays high), and `err` is high in the next cycle.
- R11: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request pulse |
| op | input | 4 | Operation code (see R4 to R6) |
| col | input | 12 | Column address |
| row | input | 17 | Row (page) address |
| wdata | input | 8 | Program payload byte |
| wlast | input | 1 | Marks the final payload byte |
| rb_n | input | 1 | Flash ready/busy, low while busy |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| io_out | output | 8 | Byte driven onto the flash I/O |
| io_oe | output | 1 | I/O output enable |
| data_ack | output | 1 | Payload byte taken |
| done | output | 1 | Operation complete pulse |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Request rejected pulse |

## Verification
The flash side latches on the rising edge of `we_n`. The monitor therefore records a byte at the first sample after `we_n` rises, and checks that the low run before that rise lasted exactly `TLOW` samples. `err` is due one cycle after the rejected `start`. `done` is due one cycle after `rb_n` is driven high, or within a bounded window after the last byte for single-command operations. The bench samples each of these on the falling edge at that exact offset. Payload bytes are checked in the cycle where `data_ack` is high, which is the first cycle of their slot.

// File: rtl/nand_bus_seq.sv
module nand_bus_seq #(
  parameter int TLOW  = 2,
  parameter int THIGH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op,
  input  logic [11:0] col,
  input  logic [16:0] row,
  input  logic [7:0]  wdata,
  input  logic        wlast,
  input  logic        rb_n,
  output logic        ce_n,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic [7:0]  io_out,
  output logic        io_oe,
  output logic        data_ack,
  output logic        done,
  output logic        busy,
  output logic        err
);

  localparam int CMAX = (TLOW > THIGH) ? TLOW : THIGH;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LO_END = CW'(TLOW - 1);
  localparam logic [CW-1:0] HI_END = CW'(THIGH - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DATA, S_CMD2, S_WBSY, S_WRDY, S_DONE
  } st_t;

  st_t         st;
  logic [3:0]  op_q;
  logic [11:0] col_q;
  logic [16:0] row_q;
  logic [2:0]  aidx;
  logic        ph;
  logic [CW-1:0] cnt;
  logic [7:0]  dbyte;
  logic        dlast, ack_q, err_q;

  logic [7:0] c1, c2, abyte;
  logic       two_cmd, row_only, has_data;

  always_comb begin
    c1 = 8'h00; c2 = 8'h00;
    two_cmd = 1'b1; row_only = 1'b0; has_data = 1'b0;
    case (op_q)
      4'd0: begin c1 = 8'h00; c2 = 8'h30; end
      4'd1: begin c1 = 8'h00; c2 = 8'h35; end
      4'd2: begin c1 = 8'h80; c2 = 8'h10; has_data = 1'b1; end
      4'd3: begin c1 = 8'h80; c2 = 8'h15; has_data = 1'b1; end
      4'd4: begin c1 = 8'h85; c2 = 8'h10; end
      4'd5: begin c1 = 8'h60; c2 = 8'hD0; row_only = 1'b1; end
      4'd6: begin c1 = 8'h70; two_cmd = 1'b0; end
      4'd7: begin c1 = 8'h90; two_cmd = 1'b0; end
      default: begin c1 = 8'hFF; two_cmd = 1'b0; end
    endcase
  end

  always_comb begin
    case (aidx)
      3'd0:    abyte = col_q[7:0];
      3'd1:    abyte = {4'b0, col_q[11:8]};
      3'd2:    abyte = row_q[7:0];
      3'd3:    abyte = row_q[15:8];
      default: abyte = {7'b0, row_q[16]};
    endcase
  end

  wire in_slot  = (st == S_CMD1) || (st == S_ADDR) || (st == S_DATA) || (st == S_CMD2);
  wire slot_end = in_slot && ph && (cnt == HI_END);
  wire op_ok    = (op <= 4'd8);

  assign busy     = (st != S_IDLE);
  assign ce_n     = (st == S_IDLE);
  assign io_oe    = in_slot;
  assign we_n     = !(in_slot && !ph);
  assign cle      = (st == S_CMD1) || (st == S_CMD2);
  assign ale      = (st == S_ADDR);
  assign done     = (st == S_DONE);
  assign data_ack = ack_q;
  assign err      = err_q;

  always_comb begin
    case (st)
      S_CMD1:  io_out = c1;
      S_ADDR:  io_out = abyte;
      S_DATA:  io_out = dbyte;
      S_CMD2:  io_out = c2;
      default: io_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; col_q <= '0; row_q <= '0; aidx <= '0;
      ph <= 1'b0; cnt <= '0; dbyte <= '0; dlast <= 1'b0;
      ack_q <= 1'b0; err_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      err_q <= start && (busy || !op_ok);

      if (in_slot) begin
        if (!ph) begin
          if (cnt == LO_END) begin ph <= 1'b1; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end else if (cnt == HI_END) begin
          ph <= 1'b0; cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end

      case (st)
        S_IDLE: if (start && op_ok) begin
          st <= S_CMD1; op_q <= op; col_q <= col; row_q <= row;
        end
        S_CMD1: if (slot_end) begin
          if (two_cmd) begin
            st <= S_ADDR; aidx <= row_only ? 3'd2 : 3'd0;
          end else st <= S_DONE;
        end
        S_ADDR: if (slot_end) begin
          if (aidx == 3'd4) begin
            if (has_data) begin
              st <= S_DATA; dbyte <= wdata; dlast <= wlast; ack_q <= 1'b1;
            end else st <= S_CMD2;
          end else aidx <= aidx + 1'b1;
        end
        S_DATA: if (slot_end) begin
          if (dlast) st <= S_CMD2;
          else begin dbyte <= wdata; dlast <= wlast; ack_q <= 1'b1; end
        end
        S_CMD2: if (slot_end) st <= S_WBSY;
        S_WBSY: if (!rb_n) st <= S_WRDY;
        S_WRDY: if (rb_n) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_bus_seq_chk.sv
module nand_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       ce_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic [7:0] io_out,
  input logic       io_oe,
  input logic       data_ack,
  input logic       done,
  input logic       busy,
  input logic       err
);

  // R3
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));

  // R2
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !ce_n);

  // R2
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R9
  busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && busy) |=> err);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (we_n && !io_oe && !cle && !ale && !data_ack));

  // R7
  ack_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ack |-> (!we_n && !cle && !ale));

endmodule

bind nand_bus_seq nand_bus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ce_n(ce_n), .cle(cle), .ale(ale),
  .we_n(we_n), .io_out(io_out), .io_oe(io_oe), .data_ack(data_ack),
  .done(done), .busy(busy), .err(err)
);

// File: tb/nand_bus_seq_tb_top.sv
module nand_bus_seq_tb_top;
  localparam int TLOW = 3, THIGH = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wlast = 1'b0, rb_n = 1'b1;
  logic [3:0] op = '0;
  logic [11:0] col = '0;
  logic [16:0] row = '0;
  logic [7:0] wdata = '0;
  logic ce_n, cle, ale, we_n, io_oe, data_ack, done, busy, err;
  logic [7:0] io_out;

  always #5 clk = ~clk;

  nand_bus_seq #(.TLOW(TLOW), .THIGH(THIGH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .col(col), .row(row),
    .wdata(wdata), .wlast(wlast), .rb_n(rb_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .io_out(io_out), .io_oe(io_oe), .data_ack(data_ack),
    .done(done), .busy(busy), .err(err));

  int nchk = 0, nfail = 0;
  logic [9:0] exp_q[$];
  logic [7:0] pay[$];
  int pidx = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: kind 1 command, 2 address, 3 data
  logic prev_we = 1'b1;
  int lowcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) lowcnt++;
      if (we_n && !prev_we) begin
        logic [1:0] kind;
        logic [9:0] got, want;
        kind = (cle && !ale) ? 2'd1 : (ale && !cle) ? 2'd2 : (!cle && !ale) ? 2'd3 : 2'd0;
        got = {kind, io_out};
        check(lowcnt == TLOW, "R2 we_n low width", lowcnt, TLOW);
        check(!ce_n, "R2 ce_n low in slot", ce_n, 0);
        if (exp_q.size() == 0) check(0, "R4 unexpected bus byte", got, 0);
        else begin
          want = exp_q.pop_front();
          check(got == want, "R3/R4/R5 bus byte", got, want);
        end
        lowcnt = 0;
      end
      if (data_ack) begin
        check(io_out == pay[pidx] && !cle && !ale, "R7 payload on ack", io_out, pay[pidx]);
        pidx++;
        if (pidx < pay.size()) begin
          wdata = pay[pidx];
          wlast = (pidx == pay.size() - 1);
        end
      end
    end
    prev_we = we_n;
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  function automatic logic [7:0] c1_of(input int o);
    case (o) 0,1: return 8'h00; 2,3: return 8'h80; 4: return 8'h85; 5: return 8'h60;
      6: return 8'h70; 7: return 8'h90; default: return 8'hFF; endcase
  endfunction
  function automatic logic [7:0] c2_of(input int o);
    case (o) 0: return 8'h30; 1: return 8'h35; 2,4: return 8'h10; 3: return 8'h15;
      default: return 8'hD0; endcase
  endfunction

  task automatic run_op(input int o, input logic [11:0] c, input logic [16:0] r, input int nbytes, input bit poke);
    int t;
    exp_q.push_back({2'd1, c1_of(o)});
    if (o <= 5) begin
      if (o != 5) begin
        exp_q.push_back({2'd2, c[7:0]});
        exp_q.push_back({2'd2, 4'b0, c[11:8]});
      end
      exp_q.push_back({2'd2, r[7:0]});
      exp_q.push_back({2'd2, r[15:8]});
      exp_q.push_back({2'd2, 7'b0, r[16]});
      pay.delete(); pidx = 0;
      for (int i = 0; i < nbytes; i++) begin
        pay.push_back(8'(8'h5A ^ (i * 37)));
        exp_q.push_back({2'd3, pay[i]});
      end
      if (nbytes > 0) begin wdata = pay[0]; wlast = (nbytes == 1); end
      exp_q.push_back({2'd1, c2_of(o)});
    end
    op = 4'(o); col = c; row = r;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 0, "R9 no err on accepted start", err, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      op = 4'd8; start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(err == 1, "R9 err after start while busy", err, 1);
      @(negedge clk);
      check(err == 0, "R9 err single cycle", err, 0);
    end
    t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    check(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    if (o <= 5) begin
      repeat (THIGH + 2) @(negedge clk);
      check(done == 0, "R8 no done before busy", done, 0);
      rb_n = 1'b0;
      repeat (4) @(negedge clk);
      check(done == 0, "R8 no done while busy", done, 0);
      rb_n = 1'b1;
      @(negedge clk);
      check(done == 1, "R8 done after ready", done, 1);
    end else begin
      t = 0;
      while (!done && t < 20) begin @(negedge clk); t++; end
      check(done == 1, "R6 done without rb_n wait", done, 1);
    end
    @(negedge clk);
    check(done == 0, "R11 done one cycle", done, 0);
    check(ce_n == 1 && busy == 0, "R1 idle after op", {ce_n, busy}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ce_n && we_n && !cle && !ale && !io_oe && !done && !err && !busy && !data_ack,
          "R1 reset outputs", {ce_n, we_n, cle, ale, io_oe, done, err, busy}, 8'hC0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(0, 12'h83F, 17'h1ABCD, 0, 0);   // R4 read, column 2111
    run_op(1, 12'h000, 17'h00001, 0, 0);   // R4 read for copy-back
    run_op(2, 12'h123, 17'h10203, 4, 0);   // R7 page program
    run_op(3, 12'h800, 17'h0FFFF, 1, 0);   // R7 cache program, single byte
    run_op(4, 12'h7FF, 17'h1FFFF, 0, 0);   // R4 copy-back program
    run_op(5, 12'hABC, 17'h15A3C, 0, 1);   // R5 erase, R9 poke while busy
    run_op(6, 12'h000, 17'h0, 0, 0);       // R6 status
    run_op(7, 12'h000, 17'h0, 0, 0);       // R6 id
    run_op(8, 12'h000, 17'h0, 0, 0);       // R6 reset
    // R10 undefined code
    op = 4'hC;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 1, "R10 err on bad code", err, 1);
    begin
      bit quiet = 1;
      repeat (8) begin @(negedge clk); if (!ce_n || busy) quiet = 0; end
      check(quiet, "R10 no bus activity", quiet, 1);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule